// File: doc/BRIEF.md
# Synchronized Center-Aligned PWM Channel

This block is one channel of a symmetric pulse-width modulator. A time-base counter ramps up from zero to a programmed period and back down again, so one PWM cycle lasts twice the period in clocks. A compare value sets the output when the counter passes it on the way up and clears it when the counter passes it on the way down. This gives a pulse centred on the counter peak. A dead-band stage turns this raw waveform into an active-high complementary pair. Each output has its own turn-on delay, so the two switches of a half-bridge never conduct together.

Several channels can run in lock-step. A master channel emits a one-clock sync pulse each time its counter reaches zero. A slave either forwards its incoming sync to its own sync output or emits its own zero pulse. When phase loading is on, the slave jumps its counter to a programmed phase value and direction on an incoming sync. Two clocks pass between the master's zero count and the slave's load. A phase of 2 counting up therefore makes the slave's counter identical to the master's.

Software writes the period and compare values into shadow registers. These values take effect only when the counter is at zero, so a PWM cycle never mixes old and new values. The phase, delay and mode settings take effect at once.

Top module: `sync_pwm_channel`

## Requirements
- R1: An active-low synchronous reset sets the counter to zero and the direction to up. It drives both outputs and sync out low, clears period, compare and phase to 0, and sets both dead-band delays to 300 clocks.
- R2: With an active period P > 0, the counter steps by exactly one each clock through the cycle 0,1,…,P,P-1,…,1 (length 2P). With P = 0 it holds at zero.
- R3: Period (address 0) and compare (address 1) writes go to shadow registers. A shadow value moves into the active register on the clock edge where the counter reads zero, so the running cycle finishes with the old values.
- R4: For 0 < C < P, the raw output sets on the clock after the counter equals C while counting up and clears on the clock after it equals C while counting down. It is high for 2(P-C) clocks of every cycle.
- R5: With C = 0 (and P > 0) the raw output stays high for the whole cycle. With C ≥ P it stays low. No glitch pulse appears in either case.
- R6: The high output turns on only after the raw output has been high for the rise delay (address 3), and the low output only after it has been low for the fall delay (address 4). Per cycle the high output is on for 2(P-C) minus the rise delay and the low output for 2C minus the fall delay.
- R7: A raw pulse no longer than its delay produces no pulse on that output, and the high and low outputs are never on together.
- R8: With mode bit 2 = 0, sync out is a one-clock pulse in the clock after the counter reads zero, so the counter reads 1 while it is high. With mode bit 2 = 1, sync out follows sync in in the same clock.
- R9: With mode bit 0 = 1, sync in high in one clock makes the counter equal the phase value (address 2) in the next. It then counts down if mode bit 1 = 1, up otherwise. A slave with phase 0 reads 0 while its master reads 2. A slave with phase 2 counting up matches its master every clock.
- R10: With mode bit 0 = 0, sync in is ignored and the counter keeps stepping by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 period, 1 compare, 2 phase, 3 rise delay, 4 fall delay, 5 mode |
| wr_data | input | CNT_W | Write data (delays take the low DB_W bits, mode takes bits 2:0) |
| sync_in | input | 1 | Sync pulse from an upstream channel |
| sync_out | output | 1 | Sync pulse to downstream channels |
| count | output | CNT_W | Current time-base counter value |
| pwm_hi | output | 1 | Delayed primary output |
| pwm_lo | output | 1 | Delayed complementary output |

## Verification
The hardest case to reach from the ports is the alignment of a slave to its master at the exact clock of a phase load. It needs a second channel whose sync input is driven by a real zero event rather than a bench-made pulse. The bench chains two instances, gives both the same period, and samples the slave's counter one and two clocks after the master's sync pulse. It does this for phase 0, phase 2 up and phase 7 down. It then turns phase loading off, shortens the slave's period, and checks over several master periods that the slave's counter never jumps.

// File: rtl/pwm_chan_pkg.sv
`timescale 1ns/1ps
package pwm_chan_pkg;
    typedef enum logic [2:0] {
        REG_PERIOD   = 3'd0,
        REG_COMPARE  = 3'd1,
        REG_PHASE    = 3'd2,
        REG_RISE_DLY = 3'd3,
        REG_FALL_DLY = 3'd4,
        REG_MODE     = 3'd5
    } reg_sel_e;

    localparam int MODE_PHASE_EN   = 0;
    localparam int MODE_PHASE_DOWN = 1;
    localparam int MODE_SYNC_PASS  = 2;
    localparam int MODE_W          = 3;
endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] prd_shadow_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic             phase_en_i,
    input  logic             phase_down_i,
    input  logic             sync_in_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] prd_act_o,
    output logic             dir_up_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] prd;
        logic             up;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      sync_ld;

    always_comb begin
        st_d    = st_q;
        sync_ld = phase_en_i && sync_in_i;
        if (st_q.cnt == '0) begin
            st_d.prd = prd_shadow_i;
        end
        if (sync_ld) begin
            st_d.cnt = phase_i;
            st_d.up  = !phase_down_i;
        end else if (st_q.prd == '0) begin
            st_d.cnt = '0;
            st_d.up  = 1'b1;
        end else if (st_q.up) begin
            if (st_q.cnt >= st_q.prd) begin
                st_d.cnt = st_q.cnt - ONE;
                st_d.up  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end else if (st_q.cnt == '0) begin
            st_d.cnt = ONE;
            st_d.up  = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.prd <= '0;
            st_q.up  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign prd_act_o = st_q.prd;
    assign dir_up_o  = st_q.up;

    assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_ld && st_q.prd != '0) |=>
        ((st_q.cnt == $past(st_q.cnt) + ONE) || (st_q.cnt == $past(st_q.cnt) - ONE)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_ld && st_q.prd == '0) |=> (st_q.cnt == '0));

    assert_period_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |=> (st_q.prd == $past(prd_shadow_i)));

    assert_phase_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ld |=> (st_q.cnt == $past(phase_i)));

    assert_ignore_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_en_i && st_q.prd != '0) |=> (st_q.cnt != $past(st_q.cnt)));
endmodule

// File: rtl/pwm_action.sv
`timescale 1ns/1ps
module pwm_action #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cmp_shadow_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] prd_act_i,
    input  logic             dir_up_i,
    output logic             raw_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             raw;
    } act_state_t;

    act_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cnt_i == '0) begin
            st_d.cmp = cmp_shadow_i;
        end
        if (st_q.cmp >= prd_act_i) begin
            st_d.raw = 1'b0;
        end else if (st_q.cmp == '0) begin
            st_d.raw = 1'b1;
        end else if (cnt_i == st_q.cmp) begin
            st_d.raw = dir_up_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o = st_q.raw;

    assert_compare_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0) |=> (st_q.cmp == $past(cmp_shadow_i)));

    assert_set_rising_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_up_i && cnt_i == st_q.cmp && st_q.cmp != '0 && st_q.cmp < prd_act_i) |=> st_q.raw);

    assert_clear_falling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_up_i && cnt_i == st_q.cmp && st_q.cmp != '0 && st_q.cmp < prd_act_i) |=> !st_q.raw);

    assert_full_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cmp >= prd_act_i) |=> !st_q.raw);

    assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cmp == '0 && prd_act_i != '0) |=> st_q.raw);
endmodule

// File: rtl/pwm_deadband.sv
`timescale 1ns/1ps
module pwm_deadband #(
    parameter int DB_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_i,
    input  logic [DB_W-1:0] rise_i,
    input  logic [DB_W-1:0] fall_i,
    output logic            pri_o,
    output logic            comp_o
);
    localparam logic [DB_W-1:0] ONE = DB_W'(1);

    typedef struct packed {
        logic [DB_W-1:0] rcnt;
        logic [DB_W-1:0] fcnt;
        logic            pri;
        logic            comp;
    } db_state_t;

    db_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_i) begin
            st_d.fcnt = '0;
            if (st_q.rcnt < rise_i) begin
                st_d.rcnt = st_q.rcnt + ONE;
            end
        end else begin
            st_d.rcnt = '0;
            if (st_q.fcnt < fall_i) begin
                st_d.fcnt = st_q.fcnt + ONE;
            end
        end
        st_d.pri  = raw_i && (st_q.rcnt >= rise_i);
        st_d.comp = !raw_i && (st_q.fcnt >= fall_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pri_o  = st_q.pri;
    assign comp_o = st_q.comp;

    assert_never_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.pri && st_q.comp));

    assert_pri_follows_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pri) |-> $past(raw_i));

    assert_comp_follows_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.comp) |-> !$past(raw_i));
endmodule

// File: rtl/sync_pwm_channel.sv
`timescale 1ns/1ps
module sync_pwm_channel
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DB_W   = 10,
    parameter int DB_RST = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             sync_in,
    output logic             sync_out,
    output logic [CNT_W-1:0] count,
    output logic             pwm_hi,
    output logic             pwm_lo
);
    localparam logic [DB_W-1:0] DB_INIT = DB_W'(DB_RST);

    typedef struct packed {
        logic [CNT_W-1:0]  prd;
        logic [CNT_W-1:0]  cmp;
        logic [CNT_W-1:0]  phase;
        logic [DB_W-1:0]   rise;
        logic [DB_W-1:0]   fall;
        logic [MODE_W-1:0] mode;
        logic              zero_pulse;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] prd_act_w;
    logic             dir_up_w;
    logic             raw_w;

    always_comb begin
        st_d            = st_q;
        st_d.zero_pulse = (cnt_w == '0);
        if (wr_en) begin
            case (wr_addr)
                REG_PERIOD:   st_d.prd   = wr_data;
                REG_COMPARE:  st_d.cmp   = wr_data;
                REG_PHASE:    st_d.phase = wr_data;
                REG_RISE_DLY: st_d.rise  = wr_data[DB_W-1:0];
                REG_FALL_DLY: st_d.fall  = wr_data[DB_W-1:0];
                REG_MODE:     st_d.mode  = wr_data[MODE_W-1:0];
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prd        <= '0;
            st_q.cmp        <= '0;
            st_q.phase      <= '0;
            st_q.rise       <= DB_INIT;
            st_q.fall       <= DB_INIT;
            st_q.mode       <= '0;
            st_q.zero_pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    pwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .prd_shadow_i (st_q.prd),
        .phase_i      (st_q.phase),
        .phase_en_i   (st_q.mode[MODE_PHASE_EN]),
        .phase_down_i (st_q.mode[MODE_PHASE_DOWN]),
        .sync_in_i    (sync_in),
        .cnt_o        (cnt_w),
        .prd_act_o    (prd_act_w),
        .dir_up_o     (dir_up_w)
    );

    pwm_action #(.CNT_W(CNT_W)) u_action (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_shadow_i (st_q.cmp),
        .cnt_i        (cnt_w),
        .prd_act_i    (prd_act_w),
        .dir_up_i     (dir_up_w),
        .raw_o        (raw_w)
    );

    pwm_deadband #(.DB_W(DB_W)) u_deadband (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_w),
        .rise_i (st_q.rise),
        .fall_i (st_q.fall),
        .pri_o  (pwm_hi),
        .comp_o (pwm_lo)
    );

    assign count    = cnt_w;
    assign sync_out = st_q.mode[MODE_SYNC_PASS] ? sync_in : st_q.zero_pulse;

    assert_zero_emits_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_w == '0 && !st_q.mode[MODE_SYNC_PASS]) |=>
        (sync_out || st_q.mode[MODE_SYNC_PASS]));

    assert_quiet_off_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_w != '0 && !st_q.mode[MODE_SYNC_PASS] && !wr_en) |=> !sync_out);
endmodule

// File: tb/sync_pwm_channel_tb.sv
`timescale 1ns/1ps
module sync_pwm_channel_tb;
    import pwm_chan_pkg::*;

    localparam int CW = 16;
    localparam int NV = 7;
    // period, compare, rise delay, fall delay
    localparam int VEC [NV][4] = '{
        '{10, 4, 2, 3}, '{20, 5, 0, 0}, '{12, 0, 3, 2}, '{12, 12, 1, 1},
        '{16, 14, 6, 2}, '{16, 20, 4, 3}, '{30, 10, 5, 5}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_wr_en = 1'b0, s_wr_en = 1'b0;
    logic [2:0]    m_wr_addr = '0, s_wr_addr = '0;
    logic [CW-1:0] m_wr_data = '0, s_wr_data = '0;
    logic          m_sync_out, s_sync_out, m_hi, m_lo, s_hi, s_lo;
    logic [CW-1:0] m_count, s_count;
    int            checks = 0, errors = 0, overlaps = 0;

    always #2.5 clk = ~clk;

    sync_pwm_channel u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(m_wr_en), .wr_addr(m_wr_addr),
        .wr_data(m_wr_data), .sync_in(1'b0), .sync_out(m_sync_out),
        .count(m_count), .pwm_hi(m_hi), .pwm_lo(m_lo));

    sync_pwm_channel u_slv (
        .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .wr_addr(s_wr_addr),
        .wr_data(s_wr_data), .sync_in(m_sync_out), .sync_out(s_sync_out),
        .count(s_count), .pwm_hi(s_hi), .pwm_lo(s_lo));

    always @(negedge clk) begin
        if (rst_n && ((m_hi && m_lo) || (s_hi && s_lo))) overlaps++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit slv, input logic [2:0] a, input int d);
        if (slv) begin s_wr_en = 1'b1; s_wr_addr = a; s_wr_data = CW'(d); end
        else     begin m_wr_en = 1'b1; m_wr_addr = a; m_wr_data = CW'(d); end
        @(negedge clk);
        m_wr_en = 1'b0;
        s_wr_en = 1'b0;
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (!m_sync_out);
    endtask

    function automatic int tri_f(input int x, input int p);
        int m = x % (2 * p);
        return (m <= p) ? m : 2 * p - m;
    endfunction

    // starts at the negedge of a master sync pulse (count reads 1)
    task automatic measure(input int p, output int hi_n, output int lo_n,
                           output int bad, output int mx);
        hi_n = 0; lo_n = 0; bad = 0; mx = 0;
        for (int j = 0; j < 2 * p; j++) begin
            if (j > 0) @(negedge clk);
            if (int'(m_count) != tri_f(j + 1, p)) bad++;
            if (int'(m_count) > mx) mx = int'(m_count);
            hi_n += int'(m_hi);
            lo_n += int'(m_lo);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi_n, lo_n, bad, mx, p, c, r, f, len, e_hi, e_lo, prev;
        string tag;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(m_count == '0, "R1 count in reset", int'(m_count), 0);
        chk(!m_hi && !m_lo, "R1 outputs in reset", int'({m_hi, m_lo}), 0);
        chk(!m_sync_out, "R1 sync out in reset", int'(m_sync_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of duty/dead-band vectors on the master (R2 R4 R5 R6 R7)
        for (int v = 0; v < NV; v++) begin
            p = VEC[v][0]; c = VEC[v][1]; r = VEC[v][2]; f = VEC[v][3];
            wr(0, REG_PERIOD, p); wr(0, REG_COMPARE, c);
            wr(0, REG_RISE_DLY, r); wr(0, REG_FALL_DLY, f);
            repeat (4) wait_sync();
            measure(p, hi_n, lo_n, bad, mx);
            len  = (c == 0) ? 2 * p : (c >= p) ? 0 : 2 * (p - c);
            e_hi = (len == 2 * p) ? len : (len > r ? len - r : 0);
            e_lo = (len == 0) ? 2 * p : ((2 * p - len) > f ? 2 * p - len - f : 0);
            if (c == 0 || c >= p)            tag = "R5";
            else if (len <= r)               tag = "R7";
            else if (r == 0 && f == 0)       tag = "R4";
            else                             tag = "R6";
            chk(bad == 0, "R2 triangle sequence", bad, 0);
            chk(hi_n == e_hi, {tag, " high width"}, hi_n, e_hi);
            chk(lo_n == e_lo, {tag, " low width"}, lo_n, e_lo);
        end

        // R3: shadow values wait for the zero count
        wr(0, REG_PERIOD, 20); wr(0, REG_COMPARE, 5);
        wr(0, REG_RISE_DLY, 0); wr(0, REG_FALL_DLY, 0);
        repeat (4) wait_sync();
        chk(m_count == CW'(1), "R8 count during sync pulse", int'(m_count), 1);
        wr(0, REG_COMPARE, 6);
        wr(0, REG_PERIOD, 8);
        hi_n = 0; mx = 0;
        do begin
            hi_n += int'(m_hi);
            if (int'(m_count) > mx) mx = int'(m_count);
            @(negedge clk);
        end while (!m_sync_out);
        chk(mx == 20, "R3 old period kept", mx, 20);
        chk(hi_n == 30, "R3 old compare kept", hi_n, 30);
        measure(8, hi_n, lo_n, bad, mx);
        chk(mx == 8 && bad == 0, "R3 new period applied", mx, 8);
        chk(hi_n == 4, "R3 new compare applied", hi_n, 4);

        // R9: slave phase alignment
        wr(0, REG_PERIOD, 20);
        wr(1, REG_PERIOD, 20); wr(1, REG_COMPARE, 5);
        wr(1, REG_PHASE, 2); wr(1, REG_MODE, 1);
        repeat (4) wait_sync();
        @(negedge clk);
        chk(s_count == m_count, "R9 phase 2 aligned at load", int'(s_count), int'(m_count));
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (s_count != m_count) bad++;
        end
        chk(bad == 0, "R9 lock-step over a cycle", bad, 0);
        wr(1, REG_PHASE, 0);
        wait_sync();
        @(negedge clk);
        chk(s_count == '0 && m_count == CW'(2), "R9 two-clock latency",
            int'(s_count), 0);
        wr(1, REG_PHASE, 7); wr(1, REG_MODE, 3);
        wait_sync();
        @(negedge clk);
        chk(s_count == CW'(7), "R9 phase load down", int'(s_count), 7);
        @(negedge clk);
        chk(s_count == CW'(6), "R9 counts down after load", int'(s_count), 6);

        // R10 and R8: phase loading off, own zero pulses
        wr(1, REG_MODE, 0); wr(1, REG_PERIOD, 15);
        repeat (2) wait_sync();
        bad = 0; mx = 0; prev = int'(s_count);
        for (int k = 0; k < 160; k++) begin
            @(negedge clk);
            if (int'(s_count) - prev != 1 && prev - int'(s_count) != 1) bad++;
            if (s_sync_out) begin
                mx++;
                if (prev != 0) bad++;
            end
            prev = int'(s_count);
        end
        chk(bad == 0, "R10 sync ignored, no jumps", bad, 0);
        chk(mx >= 4, "R8 slave emits own zero pulses", mx, 5);

        // R8: pass-through
        wr(1, REG_MODE, 4);
        bad = 0; mx = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (s_sync_out != m_sync_out) bad++;
            mx += int'(m_sync_out);
        end
        chk(bad == 0 && mx > 0, "R8 pass-through follows sync in", bad, 0);

        // R7: never both on
        chk(overlaps == 0, "R7 outputs never overlap", overlaps, 0);

        // R1: reset during operation and default delays
        rst_n = 1'b0;
        @(negedge clk);
        chk(m_count == '0 && !m_hi && !m_lo && !m_sync_out, "R1 mid-run reset",
            int'(m_count), 0);
        rst_n = 1'b1;
        wr(0, REG_PERIOD, 10); wr(0, REG_COMPARE, 4);
        repeat (3) wait_sync();
        measure(10, hi_n, lo_n, bad, mx);
        chk(bad == 0, "R1 counts up from zero after reset", bad, 0);
        chk(hi_n == 0 && lo_n == 0, "R1 default 300-clock delays", hi_n + lo_n, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule